// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped. It looks only at the frame's 48-bit destination address. The receive path gives it the address together with a one-cycle strobe. One clock later the block returns a registered keep/drop decision with its own valid flag.

Three sources can accept a frame. The first is a class rule: broadcast, multicast or unicast frames may each be accepted outright. The second is a table of 16 programmable address entries, each with its own enable bit. The third is a control word that turns table matching on and can invert the table result. When inverted, the table stops acting as a list of wanted stations and becomes a list of blocked ones.

Software programs the table entries, the enable mask and the control word through plain write ports. A write takes effect on the clock edge that follows it.

Top module: `dst_addr_filter`

## Requirements
- R1: After synchronous reset, `dec_vld` and `dec_accept` are 0. All table entries, the enable mask and the control word are cleared, so every address is rejected until software writes a setting.
- R2: A strobe on `addr_vld` yields `dec_vld`=1 exactly one clock later. `dec_vld` is 0 in any cycle that follows a cycle without a strobe. `dec_accept` is 0 whenever `dec_vld` is 0.
- R3: An address of all ones is broadcast. Control bit 2 accepts every broadcast address, whatever the table holds.
- R4: An address whose bit 40 is set and which is not all ones is multicast. Bit 40 is bit 0 of the first byte, where `addr[47:40]` is the first byte. Control bit 1 accepts every multicast address, and this bit does not accept broadcast.
- R5: Any address that is neither broadcast nor multicast is unicast. Control bit 0 accepts every unicast address, and this bit does not accept broadcast or multicast.
- R6: Control bit 4 turns table compare on. With it set, an address equal to an enabled entry is accepted. With it clear, the table has no effect on the decision.
- R7: An entry's high word holds `addr[47:16]`, and bits 31:16 of its low word hold `addr[15:0]`. Bits 15:0 of the low word take no part in the compare. A high-word write uses `ent_wr_hi`=1.
- R8: Bit i of the enable mask enables entry i. A disabled entry never matches, even when its stored address equals the strobed address.
- R9: With control bits 4 and 3 both set, an address that matches an enabled entry is rejected by the table and every other address is accepted. With bit 4 clear, bit 3 has no effect.
- R10: A control, entry or enable write made in the same cycle as a strobe does not affect that strobe's decision. It does affect the decision for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_wr_en | input | 1 | Write one word of a table entry |
| ent_wr_idx | input | 4 | Entry index to write |
| ent_wr_hi | input | 1 | 1 = high word, 0 = low word |
| ent_wr_data | input | 32 | Entry word data |
| msk_wr_en | input | 1 | Write the enable mask |
| msk_wr_data | input | 16 | Enable mask, one bit per entry |
| ctl_wr_en | input | 1 | Write the control word |
| ctl_wr_data | input | 5 | Bit 4 compare on, bit 3 invert, bit 2 broadcast, bit 1 multicast, bit 0 unicast |
| addr_vld | input | 1 | Destination address strobe |
| addr | input | 48 | Destination address, first byte in bits 47:40 |
| dec_vld | output | 1 | Decision valid, one clock after the strobe |
| dec_accept | output | 1 | 1 = keep frame |

## Verification
Every decision is due exactly one clock edge after its strobe, and writes settle on the edge after they are presented. The bench drives each strobe or write on a falling edge, removes it on the next falling edge, and reads `dec_vld`/`dec_accept` on that same falling edge, which is half a period after the capturing rising edge. For R10 the write and the strobe share one cycle. The bench then expects the old setting on the first decision and the new setting on the following strobe. For R2 the bench also reads the outputs one cycle after the decision, to confirm they have dropped.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int ADDR_W  = 48;
    localparam int WORD_W  = 32;
    localparam int LOW_W   = ADDR_W - WORD_W;
    localparam int N_ENT   = 16;
    localparam int CTL_W   = 5;
    localparam int GRP_BIT = ADDR_W - 8;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2
    } addr_class_e;

    // Field order is the control word bit order, bit 4 first.
    typedef struct packed {
        logic cmp_on;
        logic invert;
        logic take_bc;
        logic take_mc;
        logic take_uc;
    } filt_ctl_t;

    function automatic addr_class_e classify(input logic [ADDR_W-1:0] a);
        if (&a)
            return CLS_BCAST;
        else if (a[GRP_BIT])
            return CLS_MULTI;
        else
            return CLS_UNI;
    endfunction

    function automatic logic [ADDR_W-1:0] join_entry(input logic [WORD_W-1:0] hi,
                                                     input logic [LOW_W-1:0]  lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/daf_class_decode.sv
module daf_class_decode
    import daf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  filt_ctl_t         ctl,
    output addr_class_e       cls,
    output logic              class_take
);

    always_comb begin
        cls = classify(addr);
        unique case (cls)
            CLS_BCAST: class_take = ctl.take_bc;
            CLS_MULTI: class_take = ctl.take_mc;
            default:   class_take = ctl.take_uc;
        endcase
    end

endmodule

// File: rtl/daf_entry_table.sv
module daf_entry_table
    import daf_pkg::*;
#(
    parameter int ENTRIES = N_ENT,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ent_wr_en,
    input  logic [IDX_W-1:0]   ent_wr_idx,
    input  logic               ent_wr_hi,
    input  logic [WORD_W-1:0]  ent_wr_data,
    input  logic               msk_wr_en,
    input  logic [ENTRIES-1:0] msk_wr_data,
    input  logic [ADDR_W-1:0]  probe,
    output logic               hit
);

    logic [ENTRIES-1:0] msk_q;
    logic [ENTRIES-1:0] eq;

    always_ff @(posedge clk) begin
        if (rst)
            msk_q <= '0;
        else if (msk_wr_en)
            msk_q <= msk_wr_data;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [WORD_W-1:0] hi_q;
        logic [LOW_W-1:0]  lo_q;
        logic              sel;

        assign sel = ent_wr_en && (ent_wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (sel) begin
                if (ent_wr_hi)
                    hi_q <= ent_wr_data;
                else
                    lo_q <= ent_wr_data[WORD_W-1 -: LOW_W];
            end
        end

        assign eq[i] = msk_q[i] && (join_entry(hi_q, lo_q) == probe);
    end

    assign hit = |eq;

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ENTRIES = N_ENT,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ent_wr_en,
    input  logic [IDX_W-1:0]   ent_wr_idx,
    input  logic               ent_wr_hi,
    input  logic [WORD_W-1:0]  ent_wr_data,
    input  logic               msk_wr_en,
    input  logic [ENTRIES-1:0] msk_wr_data,
    input  logic               ctl_wr_en,
    input  logic [CTL_W-1:0]   ctl_wr_data,
    input  logic               addr_vld,
    input  logic [ADDR_W-1:0]  addr,
    output logic               dec_vld,
    output logic               dec_accept
);

    filt_ctl_t   ctl_q;
    addr_class_e cls;
    logic        class_take;
    logic        tbl_hit;
    logic        tbl_take;
    logic        take;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (ctl_wr_en)
            ctl_q <= filt_ctl_t'(ctl_wr_data);
    end

    daf_entry_table #(.ENTRIES(ENTRIES)) u_table (
        .clk         (clk),
        .rst         (rst),
        .ent_wr_en   (ent_wr_en),
        .ent_wr_idx  (ent_wr_idx),
        .ent_wr_hi   (ent_wr_hi),
        .ent_wr_data (ent_wr_data),
        .msk_wr_en   (msk_wr_en),
        .msk_wr_data (msk_wr_data),
        .probe       (addr),
        .hit         (tbl_hit)
    );

    daf_class_decode u_class (
        .addr       (addr),
        .ctl        (ctl_q),
        .cls        (cls),
        .class_take (class_take)
    );

    assign tbl_take = ctl_q.cmp_on && (tbl_hit ^ ctl_q.invert);
    assign take     = class_take || tbl_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_vld    <= addr_vld;
            dec_accept <= addr_vld && take;
        end
    end

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
        addr_vld |=> dec_vld);

    assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |=> !dec_vld);

    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !dec_vld |-> !dec_accept);

    assert_bcast_take_R3: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && (&addr) && ctl_q.take_bc) |=> dec_accept);

    assert_cmp_off_R6: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && !ctl_q.cmp_on && !ctl_q.take_bc && !ctl_q.take_mc && !ctl_q.take_uc)
        |=> !dec_accept);

    assert_uc_only_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && (cls == CLS_BCAST) && !ctl_q.take_bc && !ctl_q.cmp_on) |=> !dec_accept);

endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ent_wr_en = 1'b0;
    logic [3:0]  ent_wr_idx = '0;
    logic        ent_wr_hi = 1'b0;
    logic [31:0] ent_wr_data = '0;
    logic        msk_wr_en = 1'b0;
    logic [15:0] msk_wr_data = '0;
    logic        ctl_wr_en = 1'b0;
    logic [4:0]  ctl_wr_data = '0;
    logic        addr_vld = 1'b0;
    logic [47:0] addr = '0;
    logic        dec_vld;
    logic        dec_accept;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst(rst),
        .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx), .ent_wr_hi(ent_wr_hi),
        .ent_wr_data(ent_wr_data),
        .msk_wr_en(msk_wr_en), .msk_wr_data(msk_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .addr_vld(addr_vld), .addr(addr),
        .dec_vld(dec_vld), .dec_accept(dec_accept)
    );

    localparam logic [47:0] A_E0  = 48'h020000000001;
    localparam logic [47:0] A_E5  = 48'h01005E000007;
    localparam logic [47:0] A_E9  = 48'h001122334455;
    localparam logic [47:0] A_BC  = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] A_MC  = 48'h01005E000001;
    localparam logic [47:0] A_UC  = 48'h0A0000000001;
    localparam logic [47:0] A_MIS = 48'h020000000002;

    // {requirement number, control word, address, expected accept}
    localparam int NV = 18;
    localparam logic [57:0] VEC [NV] = '{
        {4'd6, 5'h00, A_E0,  1'b0},  // R6 compare off, table ignored
        {4'd6, 5'h10, A_E0,  1'b1},  // R6 enabled entry hit
        {4'd6, 5'h10, A_MIS, 1'b0},  // R6 no entry matches
        {4'd8, 5'h10, A_E9,  1'b0},  // R8 stored but disabled
        {4'd6, 5'h10, A_E5,  1'b1},  // R6 multicast entry hit
        {4'd9, 5'h18, A_E0,  1'b0},  // R9 inverted: hit rejected
        {4'd9, 5'h18, A_MIS, 1'b1},  // R9 inverted: miss accepted
        {4'd9, 5'h08, A_MIS, 1'b0},  // R9 invert without compare
        {4'd3, 5'h04, A_BC,  1'b1},  // R3 broadcast class
        {4'd4, 5'h02, A_BC,  1'b0},  // R4 multicast bit skips broadcast
        {4'd5, 5'h01, A_BC,  1'b0},  // R5 unicast bit skips broadcast
        {4'd4, 5'h02, A_MC,  1'b1},  // R4 multicast class
        {4'd5, 5'h01, A_MC,  1'b0},  // R5 unicast bit skips multicast
        {4'd5, 5'h01, A_UC,  1'b1},  // R5 unicast class
        {4'd3, 5'h04, A_UC,  1'b0},  // R3 broadcast bit skips unicast
        {4'd4, 5'h02, A_UC,  1'b0},  // R4 multicast bit skips unicast
        {4'd5, 5'h1B, A_E0,  1'b1},  // R5 class overrides inverted hit
        {4'd9, 5'h18, A_BC,  1'b1}   // R9 inverted miss for broadcast
    };

    task automatic check(input int req, input logic vld, input logic acc,
                         input logic exp_vld, input logic exp_acc);
        checks++;
        if (vld !== exp_vld || acc !== exp_acc) begin
            fails++;
            $display("FAIL R%0d: vld/accept = %b/%b, expected %b/%b",
                     req, vld, acc, exp_vld, exp_acc);
        end
    endtask

    task automatic wr_ctl(input logic [4:0] d);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic wr_msk(input logic [15:0] d);
        @(negedge clk); msk_wr_en = 1'b1; msk_wr_data = d;
        @(negedge clk); msk_wr_en = 1'b0;
    endtask

    task automatic wr_word(input logic [3:0] idx, input logic hi, input logic [31:0] d);
        @(negedge clk); ent_wr_en = 1'b1; ent_wr_idx = idx; ent_wr_hi = hi; ent_wr_data = d;
        @(negedge clk); ent_wr_en = 1'b0;
    endtask

    task automatic wr_entry(input logic [3:0] idx, input logic [47:0] a);
        wr_word(idx, 1'b1, a[47:16]);
        wr_word(idx, 1'b0, {a[15:0], 16'h0000});
    endtask

    // Strobe on a falling edge; the decision is captured on the next rising
    // edge and read on the falling edge after it.
    task automatic strobe(input logic [47:0] a, input int req, input logic exp);
        @(negedge clk); addr_vld = 1'b1; addr = a;
        @(negedge clk); addr_vld = 1'b0;
        check(req, dec_vld, dec_accept, 1'b1, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog: cycles = %0d, expected < 20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state of outputs
        check(1, dec_vld, dec_accept, 1'b0, 1'b0);
        // R1 cleared table and mask: compare on, all-zero address still rejected
        wr_ctl(5'h10);
        strobe(48'h0, 1, 1'b0);

        wr_entry(4'd0, A_E0);
        wr_entry(4'd5, A_E5);
        wr_entry(4'd9, A_E9);
        wr_msk(16'h0021);

        for (int k = 0; k < NV; k++) begin
            wr_ctl(VEC[k][53:49]);
            strobe(VEC[k][48:1], int'(VEC[k][57:54]), VEC[k][0]);
        end

        // R2 outputs drop one cycle after the decision
        @(negedge clk);
        check(2, dec_vld, dec_accept, 1'b0, 1'b0);

        // R2 back-to-back strobes each produce a decision
        wr_ctl(5'h10);
        @(negedge clk); addr_vld = 1'b1; addr = A_E0;
        @(negedge clk); addr = A_MIS;
        check(2, dec_vld, dec_accept, 1'b1, 1'b1);
        @(negedge clk); addr_vld = 1'b0;
        check(2, dec_vld, dec_accept, 1'b1, 1'b0);

        // R7 low half of low word is ignored; only bits 31:16 compare
        wr_word(4'd3, 1'b1, 32'hAABBCCDD);
        wr_word(4'd3, 1'b0, 32'hEEFF1234);
        wr_msk(16'h0029);
        strobe(48'hAABBCCDDEEFF, 7, 1'b1);
        strobe(48'hAABBCCDD1234, 7, 1'b0);

        // R10 control write in the strobe cycle applies to the next strobe
        @(negedge clk); addr_vld = 1'b1; addr = A_E0; ctl_wr_en = 1'b1; ctl_wr_data = 5'h00;
        @(negedge clk); addr_vld = 1'b0; ctl_wr_en = 1'b0;
        check(10, dec_vld, dec_accept, 1'b1, 1'b1);
        strobe(A_E0, 10, 1'b0);

        // R10 mask write in the strobe cycle applies to the next strobe
        wr_ctl(5'h10);
        @(negedge clk); addr_vld = 1'b1; addr = A_E0; msk_wr_en = 1'b1; msk_wr_data = 16'h0000;
        @(negedge clk); addr_vld = 1'b0; msk_wr_en = 1'b0;
        check(10, dec_vld, dec_accept, 1'b1, 1'b1);
        strobe(A_E0, 10, 1'b0);

        // R8 re-enable only entry 9: its address now matches, entry 0 does not
        wr_msk(16'h0200);
        strobe(A_E9, 8, 1'b1);
        strobe(A_E0, 8, 1'b0);

        // R1 mid-run reset clears control and mask
        wr_ctl(5'h17);
        do_reset();
        strobe(A_BC, 1, 1'b0);
        wr_ctl(5'h10);
        strobe(A_E9, 1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule